// File: doc/BRIEF.md
# Two-Bit Sample Lag Accumulator

This block is one lag cell of a cross-correlator for two-bit quantised samples. Each clock it receives one sample from each of two channels. Every sample arrives as a three-wire code: a sign wire, a magnitude wire and a validity wire. The block turns each code into a signed level of plus or minus one or three. It multiplies the two levels and adds the signed product into a 27-bit accumulator on every clock edge where the accumulate strobe is high.

The accumulator has two parts: three fine bits at the bottom and a 24-bit counter above them. Only the counter is visible outside the block. A load strobe copies the counter into a 24-bit result register that holds it for readout. A clear strobe zeroes the counter and leaves the fine bits alone, so the residue below one count carries over into the next integration period. A mode input tells the block to ignore validity. In that mode the validity wire is assumed to carry other traffic, and every sample counts.

Top module: `cl_lag_correlator`

## Requirements
- R1: A sample code {sign, magnitude, validity} decodes as 001 to +1, 011 to +3, 101 to -1 and 111 to -3. A sign of 1 means negative, and a magnitude of 1 means a level of 3. One-bit data, whose magnitude is held at 1, therefore decodes to +3 or -3.
- R2: While `ign_valid` is 0, a pair in which either sample has validity 0 contributes nothing to the accumulator. This includes the illegal code 000.
- R3: While `ign_valid` is 1, the validity wire is ignored, and every sample decodes from its sign and magnitude alone. For example, code 000 gives +1.
- R4: On an edge where `acc_en` is 1 and both samples are usable, the signed product of the two levels (one of ±1, ±3, ±9) is added to the 27-bit accumulator. Each further such edge adds it again. The sum wraps modulo 2^27.
- R5: On an edge where `acc_en` is 0 and no clear occurs, the accumulator keeps its value.
- R6: On an edge where `load` is 1, `result` takes accumulator bits 26:3 as they stood before that edge, and the new value is visible after the edge. On all other edges `result` holds.
- R7: On an edge where `clear` is 1, accumulator bits 26:3 become zero. The three fine bits keep their value. If an addition occurs on the same edge, the fine bits instead take the low three bits of the sum, and its carry is discarded.
- R8: When `load` and `clear` are both 1 on the same edge, `result` receives the counter value from before the clear.
- R9: A synchronous active-low reset sets the accumulator and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| a_sign | input | 1 | Channel A sign wire |
| a_mag | input | 1 | Channel A magnitude wire |
| a_valid | input | 1 | Channel A validity wire |
| b_sign | input | 1 | Channel B sign wire |
| b_mag | input | 1 | Channel B magnitude wire |
| b_valid | input | 1 | Channel B validity wire |
| ign_valid | input | 1 | When 1, validity wires are ignored |
| acc_en | input | 1 | Accumulate strobe |
| load | input | 1 | Copy counter to result register |
| clear | input | 1 | Zero the upper counter |
| result | output | 24 | Buffered counter value |

## Verification
An accumulate takes effect at the clock edge where its strobe is sampled. A load strobe on any later edge exposes that total on `result` just after that edge. The shortest path from a sample to the output is therefore two edges.

The bench changes inputs on falling edges and reads `result` on the falling edge that follows the load edge, so every read falls half a period after the edge it depends on. For a clear, and for a clear and a load on the same edge, the bench checks the outcome with a second load issued afterwards. The directed cases use fixed expected values. The sweep compares against a running sum that the bench builds from the sample code table.

// File: rtl/cl_pkg.sv
// Package: shared widths and the sample code type for the lag accumulator.
// Assumes two-bit quantised samples; levels fit in 3 signed bits, products in 5.
package cl_pkg;

    localparam int LEVEL_W = 3;
    localparam int PROD_W  = 5;

    // One sample as seen on its three wires.
    typedef struct packed {
        logic sgn;
        logic mag;
        logic vld;
    } cl_sample_t;

endpackage

// File: rtl/cl_sample_decode.sv
// Module: maps one three-wire sample code to a signed level and a usable flag.
// Assumes the code is stable around the clock edge; purely combinational.
module cl_sample_decode
    import cl_pkg::*;
(
    input  cl_sample_t                  smp_i,
    input  logic                        ign_valid_i,
    output logic signed [LEVEL_W-1:0]   level_o,
    output logic                        usable_o
);

    // Level from sign and magnitude; usable when valid or validity is ignored.
    always_comb begin
        unique case ({smp_i.sgn, smp_i.mag})
            2'b00:   level_o = 3'sd1;
            2'b01:   level_o = 3'sd3;
            2'b10:   level_o = -3'sd1;
            default: level_o = -3'sd3;
        endcase
        usable_o = ign_valid_i | smp_i.vld;
    end

endmodule

// File: rtl/cl_lag_accum.sv
// Module: multiplies two levels and keeps a split accumulator
// (LOW_W fine bits below an UPPER_W counter) with a counter-only clear.
// Assumes synchronous single-cycle strobes; the sum wraps on overflow.
module cl_lag_accum
    import cl_pkg::*;
#(
    parameter int LOW_W   = 3,
    parameter int UPPER_W = 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic signed [LEVEL_W-1:0]   lvl_a_i,
    input  logic signed [LEVEL_W-1:0]   lvl_b_i,
    input  logic                        use_a_i,
    input  logic                        use_b_i,
    input  logic                        acc_en_i,
    input  logic                        clr_i,
    output logic [UPPER_W-1:0]          upper_o
);

    localparam int ACC_W = LOW_W + UPPER_W;
    localparam int EXT_W = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] ext_a, ext_b, prod;
    logic [ACC_W-1:0]         acc_q, prod_ext, sum;
    logic                     do_add;

    // Widen the levels, form the product and the candidate sum.
    always_comb begin
        ext_a    = $signed({{(PROD_W-LEVEL_W){lvl_a_i[LEVEL_W-1]}}, lvl_a_i});
        ext_b    = $signed({{(PROD_W-LEVEL_W){lvl_b_i[LEVEL_W-1]}}, lvl_b_i});
        prod     = ext_a * ext_b;
        prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
        sum      = acc_q + prod_ext;
        do_add   = acc_en_i & use_a_i & use_b_i;
    end

    // Accumulator register: clear zeroes the counter, fine bits follow the add.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr_i) begin
            acc_q[ACC_W-1:LOW_W] <= '0;
            if (do_add) acc_q[LOW_W-1:0] <= sum[LOW_W-1:0];
        end else if (do_add) begin
            acc_q <= sum;
        end
    end

    assign upper_o = acc_q[ACC_W-1:LOW_W];

    AST_ADD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && use_a_i && use_b_i && !clr_i) |=> acc_q == $past(acc_q) + $past(prod_ext)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en_i && !clr_i) |=> $stable(acc_q)); // R5
    AST_INVALID_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!(use_a_i && use_b_i) && !clr_i) |=> $stable(acc_q)); // R2
    AST_CLEAR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> upper_o == '0); // R7
    AST_CLEAR_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !acc_en_i) |=> $stable(acc_q[LOW_W-1:0])); // R7

endmodule

// File: rtl/cl_result_buffer.sv
// Module: readout register that captures the counter on a load strobe.
// Assumes the counter input is the pre-edge register value, so a same-edge
// clear does not disturb what is captured.
module cl_result_buffer #(
    parameter int UPPER_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [UPPER_W-1:0]  upper_i,
    output logic [UPPER_W-1:0]  result_o
);

    // Capture the counter on load, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      result_o <= '0;
        else if (load_i) result_o <= upper_i;
    end

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> result_o == $past(upper_i)); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(result_o)); // R6

endmodule

// File: rtl/cl_lag_correlator.sv
// Module: top of the lag accumulator. Decodes two sample channels, accumulates
// their product and buffers the counter for readout.
// Assumes all inputs are synchronous to clk and strobes are single-cycle.
module cl_lag_correlator
    import cl_pkg::*;
#(
    parameter int LOW_W   = 3,
    parameter int UPPER_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                a_sign,
    input  logic                a_mag,
    input  logic                a_valid,
    input  logic                b_sign,
    input  logic                b_mag,
    input  logic                b_valid,
    input  logic                ign_valid,
    input  logic                acc_en,
    input  logic                load,
    input  logic                clear,
    output logic [UPPER_W-1:0]  result
);

    localparam int NCH = 2;

    cl_sample_t                 smp   [NCH];
    logic signed [LEVEL_W-1:0]  level [NCH];
    logic                       usable[NCH];
    logic [UPPER_W-1:0]         upper;

    // Gather the port wires into sample records.
    always_comb begin
        smp[0] = '{sgn: a_sign, mag: a_mag, vld: a_valid};
        smp[1] = '{sgn: b_sign, mag: b_mag, vld: b_valid};
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
        cl_sample_decode u_dec (
            .smp_i       (smp[ch]),
            .ign_valid_i (ign_valid),
            .level_o     (level[ch]),
            .usable_o    (usable[ch])
        );

        AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (level[ch] == 3'sd1 || level[ch] == 3'sd3 ||
             level[ch] == -3'sd1 || level[ch] == -3'sd3)); // R1
        AST_INVALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (!ign_valid && !smp[ch].vld) |-> !usable[ch]); // R2
        AST_IGNORE_USES: assert property (@(posedge clk) disable iff (!rst_n)
            ign_valid |-> usable[ch]); // R3
    end

    cl_lag_accum #(.LOW_W(LOW_W), .UPPER_W(UPPER_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_a_i  (level[0]),
        .lvl_b_i  (level[1]),
        .use_a_i  (usable[0]),
        .use_b_i  (usable[1]),
        .acc_en_i (acc_en),
        .clr_i    (clear),
        .upper_o  (upper)
    );

    cl_result_buffer #(.UPPER_W(UPPER_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .upper_i  (upper),
        .result_o (result)
    );

    AST_LOAD_PRECLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (load && clear) |=> result == $past(upper)); // R8
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> result == '0); // R9

endmodule

// File: tb/cl_lag_correlator_bench.sv
module cl_lag_correlator_bench;

    logic clk = 1'b0;
    logic rst_n;
    logic a_sign, a_mag, a_valid, b_sign, b_mag, b_valid;
    logic ign_valid, acc_en, load, clear;
    logic [23:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    logic [26:0] m_acc;
    logic [23:0] m_buf;

    always #4 clk = ~clk;

    cl_lag_correlator u_cl_lag_correlator (
        .clk(clk), .rst_n(rst_n),
        .a_sign(a_sign), .a_mag(a_mag), .a_valid(a_valid),
        .b_sign(b_sign), .b_mag(b_mag), .b_valid(b_valid),
        .ign_valid(ign_valid), .acc_en(acc_en), .load(load), .clear(clear),
        .result(result)
    );

    // Level of a code per R1: magnitude 1 gives 3, sign 1 negates.
    function automatic int lvl(input logic [2:0] c);
        int v;
        v = c[1] ? 3 : 1;
        return c[2] ? -v : v;
    endfunction

    task automatic check(input string req, input logic [23:0] exp);
        n_checks++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, result, exp);
        end
    endtask

    // One clock: drive at a falling edge, update the model, return at the next falling edge.
    task automatic cyc(input logic [2:0] ca, input logic [2:0] cb,
                       input logic en, input logic ld, input logic cl, input logic ign);
        logic add;
        logic [26:0] sum;
        int p;
        {a_sign, a_mag, a_valid} = ca;
        {b_sign, b_mag, b_valid} = cb;
        acc_en = en; load = ld; clear = cl; ign_valid = ign;
        add = en && (ign || (ca[0] && cb[0]));
        p = lvl(ca) * lvl(cb);
        sum = m_acc + 27'(p);
        if (ld) m_buf = m_acc[26:3];
        if (cl) m_acc = {24'd0, add ? sum[2:0] : m_acc[2:0]};
        else if (add) m_acc = sum;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        {a_sign, a_mag, a_valid, b_sign, b_mag, b_valid} = '0;
        {ign_valid, acc_en, load, clear} = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_acc = '0;
        m_buf = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R9 reset", 24'h0);

        // Fine bits survive a clear: 5 ones, clear, then +3 carries into the counter.
        repeat (5) cyc(3'b001, 3'b001, 1, 0, 0, 0);
        cyc(3'b000, 3'b000, 0, 0, 1, 0);
        cyc(3'b000, 3'b000, 0, 1, 0, 0);
        check("R7 clear zero", 24'h0);
        cyc(3'b011, 3'b001, 1, 0, 0, 0);
        cyc(3'b000, 3'b000, 0, 1, 0, 0);
        check("R7 low bits kept", 24'h1);

        // Strobe low: products are not added.
        repeat (3) cyc(3'b011, 3'b011, 0, 0, 0, 0);
        cyc(3'b000, 3'b000, 0, 1, 0, 0);
        check("R5 strobe low", 24'h1);

        // +9 eight times: acc 8 -> 80, counter 10; result holds without a load.
        repeat (8) cyc(3'b011, 3'b011, 1, 0, 0, 0);
        check("R6 hold", 24'h1);
        cyc(3'b000, 3'b000, 0, 1, 1, 0);
        check("R8 load with clear", 24'd10);
        cyc(3'b000, 3'b000, 0, 1, 0, 0);
        check("R8 cleared after", 24'h0);

        // Clear with add in the same edge: low 7 + 1 -> 0, carry dropped.
        do_reset();
        repeat (7) cyc(3'b001, 3'b001, 1, 0, 0, 0);
        cyc(3'b001, 3'b001, 1, 0, 1, 0);
        cyc(3'b011, 3'b001, 1, 0, 0, 0);
        cyc(3'b000, 3'b000, 0, 1, 0, 0);
        check("R7 clear with add", 24'h0);

        // Wrap: -1 from zero.
        do_reset();
        cyc(3'b101, 3'b001, 1, 0, 0, 0);
        cyc(3'b000, 3'b000, 0, 1, 0, 0);
        check("R4 wrap", 24'hFFFFFF);

        // Validity handling on the illegal code.
        do_reset();
        repeat (8) cyc(3'b000, 3'b000, 1, 0, 0, 0);
        cyc(3'b000, 3'b000, 0, 1, 0, 0);
        check("R2 illegal dropped", 24'h0);
        repeat (8) cyc(3'b000, 3'b000, 1, 0, 0, 1);
        cyc(3'b000, 3'b000, 0, 1, 0, 1);
        check("R3 validity ignored", 24'h1);

        // Sweep every code pair in both modes; eight adds move the counter by the product.
        do_reset();
        for (int ign = 0; ign < 2; ign++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    repeat (8) cyc(3'(a), 3'(b), 1, 0, 0, 1'(ign));
                    cyc(3'b000, 3'b000, 0, 1, 0, 1'(ign));
                    if (ign == 1)                check("R3 sweep", m_buf);
                    else if (a[0] && b[0])       check("R1 R4 sweep", m_buf);
                    else                         check("R2 sweep", m_buf);
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule